// File: doc/BRIEF.md
# Prefix-OR Leading-One Mask Generator

This combinational block turns a W-bit input vector into a thermometer mask. A mask bit is high when the input bit at that position, or any input bit above it, is high. The result marks the leading one and every position below it. A normalization shifter uses this mask to locate the leading one, and a leading-zero count can be formed from it. The mask has no clock, no reset and no storage. It follows its input within the same evaluation.

The mask is built by a recursive odd/even parallel prefix network over OR. At each level, adjacent input pairs are ORed together, which gives W/2 pair bits. Those pair bits feed a half-width copy of the same network. The even positions of the result are taken directly from that half-width prefix. Each odd position is its own input bit ORed with the prefix of the pair above it. The recursion stops at a 2-bit leaf. The logic depth therefore grows with log2(W), and the gate count grows linearly with W.

The width W must be a power of two and at least 2; the default is 32. Bit `x_in[W-1]` is the most significant position, and `x_in[0]` is the least significant.

Top module: `prefor_mask`

## Requirements
- R1: For every bit j, `mask_out[j]` equals the OR of `x_in[W-1:j]`.
- R2: An all-zero `x_in` gives an all-zero `mask_out`.
- R3: `mask_out[W-1]` always equals `x_in[W-1]`.
- R4: `mask_out` is a thermometer code: whenever `mask_out[j]` is 1 with j > 0, `mask_out[j-1]` is also 1.
- R5: A one-hot `x_in` with its 1 at bit j gives a mask with bits j down to 0 set and all bits above j clear.
- R6: On a W=4 instance, the input 4'b0010 gives the mask 4'b0011.
- R7: On a W=2 instance, the mask is `{x_in[1], x_in[1] | x_in[0]}` for all four inputs.
- R8: The mask depends on the current input only, with no clock. A change of `x_in` between clock edges appears on `mask_out` before the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| x_in | input | W | Input vector; bit W-1 is the most significant position |
| mask_out | output | W | Prefix-OR mask, from the leading one down to bit 0 |

## Verification
A wrong pair bit or a wrong half-prefix bit inside the network appears at once in the mask, because the block holds no state. Such a fault shows up in two ways. Some position takes a value that differs from the running OR of the bits above it. Often the mask also stops being a thermometer code, with a 0 below a 1. Sweeping every one-hot input places the leading one in every pair and at every recursion level. A fault in a single odd-fix gate or in one pair gate therefore shows in the very result it corrupts.

// File: rtl/pom_pkg.sv
`timescale 1ns/1ps
// Package for the prefix-OR mask generator.
// It holds the width rule that the top module checks at elaboration.
package pom_pkg;

    // True when v is a power of two that is at least 2.
    function automatic bit is_pow2(int unsigned v);
        return (v >= 2) && ((v & (v - 1)) == 0);
    endfunction

endpackage

// File: rtl/pom_pair_stage.sv
`timescale 1ns/1ps
// Pair stage: ORs each adjacent pair of bits (2k+1, 2k) into pair bit k.
// Assumes W is even. Pair bit k covers the two positions that lie in the
// slot of bit k of the half-width prefix network below it.
module pom_pair_stage #(
    parameter  int W = 4,
    localparam int H = W / 2
) (
    input  logic [W-1:0] x_in,
    output logic [H-1:0] pair_or
);

    // One OR gate for each adjacent pair.
    for (genvar k = 0; k < H; k++) begin : g_pair
        assign pair_or[k] = x_in[2*k+1] | x_in[2*k];
    end

endmodule

// File: rtl/pom_odd_fix.sv
`timescale 1ns/1ps
// Odd-fix stage: rebuilds the full-width mask from the half-width prefix.
// half_pre[k] is the OR of every input bit from W-1 down to 2k.
// Bit 2k takes that prefix directly. Bit 2k+1 ORs its own input bit with
// the prefix of the pair above it. The top bit has no pair above it.
module pom_odd_fix #(
    parameter  int W = 4,
    localparam int H = W / 2
) (
    input  logic [H-1:0] odd_bits,
    input  logic [H-1:0] half_pre,
    output logic [W-1:0] mask
);

    // Build each pair of output bits.
    for (genvar k = 0; k < H; k++) begin : g_fix
        assign mask[2*k] = half_pre[k];
        if (k == H - 1) begin : g_top
            assign mask[2*k+1] = odd_bits[k];
        end else begin : g_mid
            assign mask[2*k+1] = odd_bits[k] | half_pre[k+1];
        end
    end

endmodule

// File: rtl/pom_prefix_node.sv
`timescale 1ns/1ps
// Recursive prefix-OR node of width W, which must be a power of two of at
// least 2. A 2-bit leaf is written out directly. Wider nodes use a pair
// stage, a half-width node and an odd-fix stage. Each level adds a constant
// depth and W/2 + W/2 - 1 OR gates, so the depth grows as log2(W) and the
// gate count grows linearly with W.
module pom_prefix_node #(
    parameter  int W = 4,
    localparam int H = W / 2
) (
    input  logic [W-1:0] x_in,
    output logic [W-1:0] mask
);

    if (W == 2) begin : g_leaf
        // Leaf: the top bit passes through, and the low bit ORs both bits.
        assign mask = {x_in[1], x_in[1] | x_in[0]};
    end else begin : g_rec
        logic [H-1:0] pair_or;
        logic [H-1:0] half_pre;
        logic [H-1:0] odd_bits;

        // Collect the odd-position inputs that the odd-fix stage needs.
        for (genvar k = 0; k < H; k++) begin : g_odd
            assign odd_bits[k] = x_in[2*k+1];
        end

        pom_pair_stage #(.W(W)) u_pair (
            .x_in    (x_in),
            .pair_or (pair_or)
        );

        pom_prefix_node #(.W(H)) u_sub (
            .x_in (pair_or),
            .mask (half_pre)
        );

        pom_odd_fix #(.W(W)) u_fix (
            .odd_bits (odd_bits),
            .half_pre (half_pre),
            .mask     (mask)
        );
    end

endmodule

// File: rtl/prefor_mask.sv
`timescale 1ns/1ps
// Top level of the prefix-OR mask generator.
// Purely combinational: mask_out[j] is the OR of x_in[W-1:j].
// Assumes W is a power of two of at least 2, and rejects any other width
// at elaboration.
module prefor_mask #(
    parameter int W = 32
) (
    input  logic [W-1:0] x_in,
    output logic [W-1:0] mask_out
);

    if (!pom_pkg::is_pow2(W)) begin : g_bad_width
        $error("prefor_mask: W must be a power of two of at least 2");
    end

    pom_prefix_node #(.W(W)) u_root (
        .x_in (x_in),
        .mask (mask_out)
    );

endmodule

// File: rtl/prefor_mask_chk.sv
`timescale 1ns/1ps
// Checker for prefor_mask. It compares the mask against a running-OR model
// and against structural rules of the mask. The block has no clock, so the
// checks are immediate assertions on the settled values.
module prefor_mask_chk #(
    parameter int W = 32
) (
    input logic [W-1:0] x_in,
    input logic [W-1:0] mask_out
);

    logic [W-1:0] run_model;
    logic         run_acc;

    // Evaluate the running-OR model and check the mask against it.
    always_comb begin
        run_acc = 1'b0;
        for (int j = W - 1; j >= 0; j--) begin
            run_acc      = run_acc | x_in[j];
            run_model[j] = run_acc;
        end
        // R1
        r1_prefix_chk: assert (mask_out == run_model)
            else $error("R1 mask %h differs from prefix model %h", mask_out, run_model);
        // R2
        r2_zero_chk: assert ((x_in != '0) || (mask_out == '0))
            else $error("R2 zero input gave mask %h", mask_out);
        // R3
        r3_top_chk: assert (mask_out[W-1] == x_in[W-1])
            else $error("R3 top mask bit differs from top input bit");
        // R4
        r4_thermo_chk: assert ((((mask_out >> 1) & ~mask_out)) == '0)
            else $error("R4 mask %h is not a thermometer code", mask_out);
    end

endmodule

bind prefor_mask prefor_mask_chk #(.W(W)) u_chk (
    .x_in     (x_in),
    .mask_out (mask_out)
);

// File: tb/prefor_mask_tb.sv
`timescale 1ns/1ps
// Scoreboard bench for prefor_mask. The driver pushes its expected masks
// into a queue, and the monitor pops them on the falling edge.
module prefor_mask_tb;

    localparam int W = 32;

    typedef struct {
        logic [W-1:0] stim;
        logic [W-1:0] expv;
        string        tag;
    } item_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] x = '0;
    logic [W-1:0] mask;
    logic [3:0]   x4 = '0;
    logic [3:0]   mask4;
    logic [1:0]   x2 = '0;
    logic [1:0]   mask2;
    item_t        sb_q[$];
    int           n_total = 0;
    int           n_fail = 0;

    always #2.5 clk = ~clk;

    prefor_mask #(.W(W)) u_dut  (.x_in(x),  .mask_out(mask));
    prefor_mask #(.W(4)) u_dut4 (.x_in(x4), .mask_out(mask4));
    prefor_mask #(.W(2)) u_dut2 (.x_in(x2), .mask_out(mask2));

    // Running-OR model taken from the requirements.
    function automatic logic [W-1:0] model(input logic [W-1:0] v);
        logic [W-1:0] r;
        logic         acc;
        acc = 1'b0;
        for (int j = W - 1; j >= 0; j--) begin
            acc  = acc | v[j];
            r[j] = acc;
        end
        return r;
    endfunction

    // Count one check and report it when it fails.
    task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] expv);
        n_total++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    // Drive one stimulus after the rising edge and queue its expected mask.
    task automatic drive(input logic [W-1:0] v, input string tag);
        @(posedge clk);
        #1;
        x = v;
        sb_q.push_back('{v, model(v), tag});
    endtask

    // Monitor: pop one item per falling edge and compare it.
    always @(negedge clk) begin
        if (rst_n && sb_q.size() > 0) begin
            item_t it;
            it = sb_q.pop_front();
            check(it.tag, mask, it.expv);
            // R4: a zero below a one is never allowed
            check("R4", (mask >> 1) & ~mask, '0);
        end
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        #100000;
        n_total++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R2 reset", mask, '0);
        @(posedge clk);
        #1;
        rst_n = 1'b1;

        drive('0, "R2");
        for (int j = 0; j < W; j++) drive(W'(1) << j, "R5");
        drive('1, "R3");
        drive({1'b1, {(W-1){1'b0}}}, "R3");
        for (int i = 0; i < 200; i++) drive($urandom, "R1");
        for (int i = 0; i < 100; i++) drive($urandom & $urandom & $urandom, "R1");
        wait (sb_q.size() == 0);
        @(negedge clk);

        // R6: the small example on a 4-wide instance
        x4 = 4'b0010;
        #1;
        check("R6", W'(mask4), W'(4'b0011));
        // R8: a change between edges appears before the next edge
        @(posedge clk);
        #1;
        x4 = 4'b0100;
        #0.5;
        check("R8", W'(mask4), W'(4'b0111));
        // R7: all inputs of the 2-bit leaf
        for (int v = 0; v < 4; v++) begin
            x2 = 2'(v);
            #1;
            check("R7", W'(mask2), W'({x2[1], x2[1] | x2[0]}));
        end

        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

endmodule